// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block sits between sixteen interrupt sources and a CPU core and turns them into one request line plus the index of the request that should be taken. A rising edge on a source sets a pending bit. A pending bit counts only when its own enable bit is set and the master enable is on. Position 0 is the exception: it is the reset position, and it counts whenever it is pending, whatever the enables hold. Among the positions that count, the lowest index wins.

When the core takes the request by pulsing acknowledge, the block clears the winner's pending bit and turns off the master enable in the same cycle. This blocks nesting until software turns the master enable back on, or until the core signals the end of its handler. On that return pulse the master enable goes back to the value it held just before the acknowledge. Software writes the per-position enables, writes the master enable, clears pending bits, and reads all of this state back through a small register port.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset all pending bits, all enable bits, the master enable and the saved master enable are 0, `irq_req_o` is low and `irq_id_o` is 0.
- R2: A 0-to-1 transition on `src_i[k]` sets pending bit k at the next clock edge. A source held high sets the bit again only after it has gone low and then high again.
- R3: For positions 1 to 15, a pending bit raises `irq_req_o` only when its enable bit and the master enable are both 1. `irq_req_o` is low when no position counts, and `irq_id_o` is then 0.
- R4: A pending bit at position 0 raises `irq_req_o` with `irq_id_o` = 0 whatever the enable bits and the master enable hold.
- R5: When several positions count, `irq_id_o` gives the lowest index among them.
- R6: An acknowledge (`irq_ack_i` high while `irq_req_o` is high) clears the pending bit of `irq_id_o`, clears the master enable and saves the old master enable, all at the same edge.
- R7: If a rising edge arrives on a source in the same cycle that this position is acknowledged, its pending bit stays set.
- R8: A write to address 0 clears every pending bit whose write-data bit is 1 and leaves the other pending bits unchanged.
- R9: A pulse on `irq_ret_i` with no acknowledge in the same cycle loads the master enable from the saved value. An acknowledge takes priority over a return, and a return takes priority over a software write.
- R10: `irq_ack_i` while `irq_req_o` is low changes neither the pending bits nor the master enable.
- R11: Register port addresses are as follows. Address 0 reads the pending bits. Address 1 reads and writes the enable bits. Address 2 writes the master enable from data bit 0, and reads the master enable in bit 0 and the saved master enable in bit 1. Address 3 reads 0. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 16 | Interrupt source levels; a rising edge raises the matching pending bit |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address for read and write |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for `reg_addr_i` |
| irq_req_o | output | 1 | Request to the core |
| irq_id_o | output | 4 | Index of the winning position |
| irq_ack_i | input | 1 | Core takes the current request |
| irq_ret_i | input | 1 | Core leaves its handler; the master enable is restored |

## Verification
Two functions can land in the same cycle. The first is a new source edge arriving while the same position is being acknowledged. The bench provokes this by raising that source in the very cycle it pulses acknowledge, then reads the pending register to check that the bit survived while the master enable still dropped. The second is a software clear meeting a source that is still held high. The bench checks that the clear holds for the following cycles, because a held level is not a new edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_PEND   = 2'd0,
    REG_ENABLE = 2'd1,
    REG_MASTER = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned N_SRC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] src_q_o,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] src_q, pend_q, rise;

  assign rise = src_i & ~src_q;

  // a new edge wins over any clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      pend_q <= '0;
    end else begin
      src_q  <= src_i;
      pend_q <= (pend_q & ~clr_i) | rise;
    end
  end

  assign src_q_o = src_q;
  assign pend_o  = pend_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N_SRC = 16,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] elig_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N_SRC:0]   seen;
  logic [N_SRC-1:0] win;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N_SRC; i++) begin : g_chain
    assign win[i]    = elig_i[i] & ~seen[i];
    assign seen[i+1] = seen[i] | elig_i[i];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (win[i]) idx_o = idx_o | IDX_W'(i);
    end
  end

  assign any_o = seen[N_SRC];
endmodule

// File: rtl/irq_master_en.sv
module irq_master_en (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic ret_i,
  input  logic sw_we_i,
  input  logic sw_val_i,
  output logic en_o,
  output logic saved_o
);
  logic en_q, saved_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      saved_q <= 1'b0;
    end else if (take_i) begin
      saved_q <= en_q;
      en_q    <= 1'b0;
    end else if (ret_i) begin
      en_q    <= saved_q;
    end else if (sw_we_i) begin
      en_q    <= sw_val_i;
    end
  end

  assign en_o    = en_q;
  assign saved_o = saved_q;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC = 16,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_SRC-1:0]      src_i,
  input  logic                  reg_we_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic [N_SRC-1:0]      reg_wdata_i,
  output logic [N_SRC-1:0]      reg_rdata_o,
  output logic                  irq_req_o,
  output logic [IDX_W-1:0]      irq_id_o,
  input  logic                  irq_ack_i,
  input  logic                  irq_ret_i
);
  localparam logic [N_SRC-1:0] NMASK_POS = N_SRC'(1);  // position 0 ignores enables

  logic [N_SRC-1:0] pend_q, src_q, en_q, elig, clr;
  logic             master_en, master_saved, take, any;
  logic [IDX_W-1:0] pick;
  reg_sel_e         sel;

  assign sel  = reg_sel_e'(reg_addr_i);
  assign take = irq_ack_i & any;
  assign clr  = (take ? (N_SRC'(1) << pick) : '0)
              | ((reg_we_i && sel == REG_PEND) ? reg_wdata_i : '0);

  irq_pend_bank #(.N_SRC(N_SRC)) u_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_i   (src_i),
    .clr_i   (clr),
    .src_q_o (src_q),
    .pend_o  (pend_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            en_q <= '0;
    else if (reg_we_i && sel == REG_ENABLE) en_q <= reg_wdata_i;
  end

  irq_master_en u_master (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .take_i   (take),
    .ret_i    (irq_ret_i),
    .sw_we_i  (reg_we_i && sel == REG_MASTER),
    .sw_val_i (reg_wdata_i[0]),
    .en_o     (master_en),
    .saved_o  (master_saved)
  );

  assign elig = pend_q & ((en_q & {N_SRC{master_en}}) | NMASK_POS);

  irq_prio_pick #(.N_SRC(N_SRC)) u_pick (
    .elig_i (elig),
    .any_o  (any),
    .idx_o  (pick)
  );

  assign irq_req_o = any;
  assign irq_id_o  = pick;

  always_comb begin
    unique case (sel)
      REG_PEND:   reg_rdata_o = pend_q;
      REG_ENABLE: reg_rdata_o = en_q;
      REG_MASTER: reg_rdata_o = N_SRC'({master_saved, master_en});
      default:    reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int unsigned N_SRC = 16,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] src_i,
  input logic [N_SRC-1:0] src_q,
  input logic [N_SRC-1:0] pend_q,
  input logic [N_SRC-1:0] en_q,
  input logic             master_en,
  input logic             master_saved,
  input logic             reg_we_i,
  input logic             irq_req_o,
  input logic [IDX_W-1:0] irq_id_o,
  input logic             irq_ack_i,
  input logic             irq_ret_i
);
  logic [N_SRC-1:0] cand, below;
  logic             took;

  assign cand  = pend_q & ((en_q & {N_SRC{master_en}}) | N_SRC'(1));
  assign below = (N_SRC'(1) << irq_id_o) - N_SRC'(1);
  assign took  = irq_ack_i & irq_req_o;

  p_edge_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(src_i & ~src_q)) |=> (($past(src_i & ~src_q) & ~pend_q) == '0));

  p_req_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> pend_q[irq_id_o] && (irq_id_o == '0 || (en_q[irq_id_o] && master_en)));

  p_no_req_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_req_o |-> (cand == '0 && irq_id_o == '0));

  p_lowest_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> ((cand & below) == '0));

  p_take_drops_master_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    took |=> (!master_en && master_saved == $past(master_en)));

  p_take_clears_pend_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (took && !src_i[irq_id_o]) |=> !pend_q[$past(irq_id_o)]);

  p_ret_restores_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ret_i && !took) |=> master_en == $past(master_saved));

  p_idle_ack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !irq_req_o && !irq_ret_i && !reg_we_i) |=>
      (master_en == $past(master_en) && ($past(pend_q) & ~pend_q) == '0));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .src_i        (src_i),
  .src_q        (src_q),
  .pend_q       (pend_q),
  .en_q         (en_q),
  .master_en    (master_en),
  .master_saved (master_saved),
  .reg_we_i     (reg_we_i),
  .irq_req_o    (irq_req_o),
  .irq_id_o     (irq_id_o),
  .irq_ack_i    (irq_ack_i),
  .irq_ret_i    (irq_ret_i)
);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] src_i = '0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        irq_req_o;
  logic [3:0]  irq_id_o;
  logic        irq_ack_i = 1'b0;
  logic        irq_ret_i = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string       tag;
    logic        req;
    logic [3:0]  id;
    logic [15:0] rd;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk_i = ~clk_i;

  irq_prio_ctrl dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_i       (src_i),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_req_o   (irq_req_o),
    .irq_id_o    (irq_id_o),
    .irq_ack_i   (irq_ack_i),
    .irq_ret_i   (irq_ret_i)
  );

  // monitor: compares at the falling edge, well away from the driving edge
  always @(negedge clk_i) begin
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (irq_req_o !== e.req || irq_id_o !== e.id || reg_rdata_o !== e.rd) begin
        errors++;
        $display("FAIL %s: req=%0b id=%0d rd=%h expected req=%0b id=%0d rd=%h",
                 e.tag, irq_req_o, irq_id_o, reg_rdata_o, e.req, e.id, e.rd);
      end
    end
  end

  // one clock edge, then pulses return to idle
  task automatic cyc();
    @(posedge clk_i);
    #2;
    irq_ack_i = 1'b0;
    irq_ret_i = 1'b0;
    reg_we_i  = 1'b0;
  endtask

  task automatic expect_at(input string tag, input logic [1:0] addr,
                           input logic req, input logic [3:0] id, input logic [15:0] rd);
    exp_t e;
    reg_addr_i = addr;
    e.tag = tag; e.req = req; e.id = id; e.rd = rd;
    sb_q.push_back(e);
    @(negedge clk_i);
    #2;
  endtask

  task automatic wr(input logic [1:0] addr, input logic [15:0] data);
    reg_we_i = 1'b1; reg_addr_i = addr; reg_wdata_i = data;
    cyc();
  endtask

  task automatic pulse_src(input logic [15:0] m);
    src_i = src_i | m;
    cyc();
    src_i = src_i & ~m;
    cyc();
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #35 rst_ni = 1'b1;
    cyc();
    // R1 reset state
    expect_at("R1 pend",   2'd0, 1'b0, 4'd0, 16'h0000);
    expect_at("R1 enable", 2'd1, 1'b0, 4'd0, 16'h0000);
    expect_at("R1 master", 2'd2, 1'b0, 4'd0, 16'h0000);
    expect_at("R11 unused addr", 2'd3, 1'b0, 4'd0, 16'h0000);

    pulse_src(16'h0020);
    expect_at("R2 edge sets pend 5", 2'd0, 1'b0, 4'd0, 16'h0020);

    wr(2'd1, 16'h0020);
    expect_at("R3 enable without master", 2'd1, 1'b0, 4'd0, 16'h0020);

    wr(2'd2, 16'h0001);
    expect_at("R3 master on", 2'd2, 1'b1, 4'd5, 16'h0001);

    pulse_src(16'h0208);
    expect_at("R3 disabled pends ignored", 2'd0, 1'b1, 4'd5, 16'h0228);
    wr(2'd1, 16'h0228);
    expect_at("R5 lowest index wins", 2'd1, 1'b1, 4'd3, 16'h0228);

    irq_ack_i = 1'b1;
    cyc();
    expect_at("R6 ack clears pend 3", 2'd0, 1'b0, 4'd0, 16'h0220);
    expect_at("R6 ack drops master", 2'd2, 1'b0, 4'd0, 16'h0002);

    irq_ack_i = 1'b1;
    cyc();
    expect_at("R10 ack without req", 2'd0, 1'b0, 4'd0, 16'h0220);
    expect_at("R10 master unchanged", 2'd2, 1'b0, 4'd0, 16'h0002);

    irq_ret_i = 1'b1;
    cyc();
    expect_at("R9 return restores master", 2'd2, 1'b1, 4'd5, 16'h0003);

    // R7 edge on position 5 in the acknowledge cycle of position 5
    irq_ack_i = 1'b1;
    src_i[5]  = 1'b1;
    cyc();
    expect_at("R7 pend 5 kept", 2'd0, 1'b0, 4'd0, 16'h0220);
    expect_at("R7 master dropped", 2'd2, 1'b0, 4'd0, 16'h0002);

    // R8 clear while source 5 is still held high
    wr(2'd0, 16'h0020);
    expect_at("R8 w1c clears pend 5", 2'd0, 1'b0, 4'd0, 16'h0200);
    cyc();
    expect_at("R2 held level no new edge", 2'd0, 1'b0, 4'd0, 16'h0200);
    src_i[5] = 1'b0;
    cyc();
    wr(2'd0, 16'h0000);
    expect_at("R8 zero bits untouched", 2'd0, 1'b0, 4'd0, 16'h0200);

    pulse_src(16'h0001);
    expect_at("R4 position 0 ignores enables", 2'd0, 1'b1, 4'd0, 16'h0201);

    irq_ret_i = 1'b1;
    cyc();
    expect_at("R5 pos 0 beats pos 9", 2'd2, 1'b1, 4'd0, 16'h0003);
    irq_ack_i = 1'b1;
    cyc();
    expect_at("R6 ack of position 0", 2'd0, 1'b0, 4'd0, 16'h0200);
    irq_ret_i = 1'b1;
    cyc();
    expect_at("R9 return then pos 9", 2'd2, 1'b1, 4'd9, 16'h0003);

    // R9 ack wins over return; return with saved 0 keeps master off
    wr(2'd2, 16'h0000);
    pulse_src(16'h0001);
    irq_ack_i = 1'b1;
    irq_ret_i = 1'b1;
    cyc();
    expect_at("R9 ack beats return", 2'd2, 1'b0, 4'd0, 16'h0000);
    irq_ret_i = 1'b1;
    reg_we_i = 1'b1; reg_addr_i = 2'd2; reg_wdata_i = 16'h0001;
    cyc();
    expect_at("R9 return beats sw write", 2'd2, 1'b0, 4'd0, 16'h0000);

    cyc();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule